// File: doc/BRIEF.md
# Indirect Register-Driven Bus Access Engine

This block lets a 64-bit control-register port reach a byte-addressed downstream peripheral bus one transaction at a time. Software first loads a command word. The command holds a direction flag, a byte count and a 32-bit target address. Software then either lets the command start a read, or writes the data register to start a write. The block issues exactly one request/acknowledge transaction per trigger. A done flag in the status register shows when that transaction has finished.

The data register is organised as one 8-byte aligned sector in big-endian order. A transfer shorter than eight bytes is not justified to the least significant byte. It occupies the register byte lanes that match the low three address bits. Read data that comes back is steered into those lanes, and the other lanes are cleared. Write data is steered from those lanes onto the bus byte lanes, and per-byte enables mark which lanes are valid.

Top module: `ind_bus_engine`

## Requirements
- R1: A register access decodes only when byte address bits [2:0] are zero. The register index is the byte address shifted right by 3. Index 0x41 is the command, 0x42 the data and 0x43 the status. A misaligned access has no effect and reads zero.
- R2: Command layout, with bit 63 as the MSB: bit 63 = read flag, bits [58:52] = size, bits [31:0] = target address. Reading the command or data register returns the last stored value.
- R3: Writing the command register with bit 63 set starts one downstream request with `dn_we` = 0 at the command's address.
- R4: Writing the command register with bit 63 clear only stores it. No request is issued and done stays set.
- R5: Writing the data register while the stored command has bit 63 clear stores the value and starts one request with `dn_we` = 1 that carries that value.
- R6: `dn_size` equals the size field when that field is 1 to 8. It is 8 when the field is 0 or greater than 8.
- R7: `dn_be[i]` is set exactly for i from the offset (address bits [2:0]) up to min(offset+size, 8)-1.
- R8: Register byte lane o (bits [63-8o:56-8o]) maps to bus byte lane o (bits [8o+7:8o]) in both directions. A completed read writes the enabled lanes into the data register and writes zero into every other lane.
- R9: Status bit 63 reads 1 when idle. It reads 0 from the cycle after a trigger until the acknowledge has been taken. All other status bits read 0.
- R10: Reading the data register before a read completes returns its previous value.
- R11: `dn_req` stays high, with address, direction and enables stable, until `dn_ack`. It drops in the following cycle. Each trigger produces exactly one request.
- R12: While a request is pending, and in the cycle in which it is acknowledged, writes to the command and data registers are ignored.
- R13: Indices 0x12, 0x13, 0x18, 0x40 and every other unmapped index read zero. Writes to them have no effect.
- R14: After reset the command and data registers are zero, done is set and `dn_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_valid | input | 1 | Register access this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | RA_W | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, same cycle |
| dn_req | output | 1 | Downstream request |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | TA_W | Downstream byte address |
| dn_size | output | 4 | Effective transfer size, 1 to 8 |
| dn_be | output | 8 | Byte-lane enables |
| dn_wdata | output | 64 | Downstream write data, lane i at bits [8i+7:8i] |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 64 | Downstream read data, lane i at bits [8i+7:8i] |

## Verification
Two events can land in the same cycle: the downstream acknowledge that ends a pending transaction, and a fresh register write that would start a new one. The bench sets the responder to acknowledge on the first cycle it sees the request. It then issues a second read command back to back with the first, so that the second write meets the acknowledge at the same edge. The bench counts that exactly one request was made and that the command register still holds the first command. A later identical write must then start a new request.

// File: rtl/ibe_pkg.sv
package ibe_pkg;
    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned WORD_W     = WORD_BYTES * 8;
    localparam int unsigned OFF_W      = $clog2(WORD_BYTES);
    localparam int unsigned CNT_W      = OFF_W + 1;

    localparam int unsigned IDX_LOG    = 'h12;
    localparam int unsigned IDX_ERR    = 'h13;
    localparam int unsigned IDX_RXSTAT = 'h18;
    localparam int unsigned IDX_BASE   = 'h40;
    localparam int unsigned IDX_CMD    = 'h41;
    localparam int unsigned IDX_DATA   = 'h42;
    localparam int unsigned IDX_STATUS = 'h43;

    localparam int unsigned CMD_RD_BIT = 63;
    localparam int unsigned SIZE_HI    = 58;
    localparam int unsigned SIZE_LO    = 52;
    localparam int unsigned SIZE_W     = SIZE_HI - SIZE_LO + 1;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_QUIET,
        RSEL_CMD,
        RSEL_DATA,
        RSEL_STATUS
    } rsel_e;

    typedef struct packed {
        logic [WORD_W-1:0] cmd;
        logic [WORD_W-1:0] data;
        logic              busy;
        logic              is_wr;
    } ibe_state_t;
endpackage

// File: rtl/ibe_reg_decode.sv
module ibe_reg_decode
    import ibe_pkg::*;
#(
    parameter int unsigned RA_W = 12
) (
    input  logic [RA_W-1:0] addr,
    output rsel_e           rsel
);
    localparam int unsigned IX_W = RA_W - 3;

    logic [IX_W-1:0] idx;
    logic            aligned;

    assign idx     = addr[RA_W-1:3];
    assign aligned = (addr[2:0] == 3'd0);

    always_comb begin
        rsel = RSEL_NONE;
        if (aligned) begin
            if (idx == IX_W'(IDX_CMD)) begin
                rsel = RSEL_CMD;
            end else if (idx == IX_W'(IDX_DATA)) begin
                rsel = RSEL_DATA;
            end else if (idx == IX_W'(IDX_STATUS)) begin
                rsel = RSEL_STATUS;
            end else if (idx == IX_W'(IDX_BASE) || idx == IX_W'(IDX_LOG) ||
                         idx == IX_W'(IDX_ERR)  || idx == IX_W'(IDX_RXSTAT)) begin
                rsel = RSEL_QUIET;
            end
        end
    end
endmodule

// File: rtl/ibe_lane_calc.sv
module ibe_lane_calc
    import ibe_pkg::*;
#(
    parameter int unsigned NB = WORD_BYTES,
    parameter int unsigned SZ_W = SIZE_W
) (
    input  logic [SZ_W-1:0]         size_raw,
    input  logic [$clog2(NB)-1:0]   offs,
    output logic [$clog2(NB):0]     size_eff,
    output logic [NB-1:0]           be
);
    localparam int unsigned CW = $clog2(NB) + 1;
    localparam int unsigned SW = CW + 1;

    logic [SW-1:0] lim;

    always_comb begin
        if (size_raw == '0 || size_raw > SZ_W'(NB)) begin
            size_eff = CW'(NB);
        end else begin
            size_eff = size_raw[CW-1:0];
        end
    end

    assign lim = SW'(offs) + SW'(size_eff);

    for (genvar i = 0; i < NB; i++) begin : g_be
        assign be[i] = (SW'(i) >= SW'(offs)) && (SW'(i) < lim);
    end
endmodule

// File: rtl/ibe_lane_swap.sv
module ibe_lane_swap #(
    parameter int unsigned NB = 8
) (
    input  logic [NB*8-1:0] din,
    input  logic [NB-1:0]   keep,
    output logic [NB*8-1:0] dout
);
    for (genvar o = 0; o < NB; o++) begin : g_lane
        assign dout[(NB-1-o)*8 +: 8] = keep[o] ? din[o*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/ind_bus_engine.sv
module ind_bus_engine
    import ibe_pkg::*;
#(
    parameter int unsigned RA_W = 12,
    parameter int unsigned TA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              dn_req,
    output logic              dn_we,
    output logic [TA_W-1:0]   dn_addr,
    output logic [CNT_W-1:0]  dn_size,
    output logic [WORD_BYTES-1:0] dn_be,
    output logic [WORD_W-1:0] dn_wdata,
    input  logic              dn_ack,
    input  logic [WORD_W-1:0] dn_rdata
);
    ibe_state_t st_d, st_q;
    rsel_e      rsel;
    logic [WORD_W-1:0] rd_lanes;
    logic       wr_en;

    ibe_reg_decode #(.RA_W(RA_W)) u_dec (
        .addr (reg_addr),
        .rsel (rsel)
    );

    ibe_lane_calc #(.NB(WORD_BYTES), .SZ_W(SIZE_W)) u_lanes (
        .size_raw (st_q.cmd[SIZE_HI:SIZE_LO]),
        .offs     (st_q.cmd[OFF_W-1:0]),
        .size_eff (dn_size),
        .be       (dn_be)
    );

    ibe_lane_swap #(.NB(WORD_BYTES)) u_rd_swap (
        .din  (dn_rdata),
        .keep (dn_be),
        .dout (rd_lanes)
    );

    ibe_lane_swap #(.NB(WORD_BYTES)) u_wr_swap (
        .din  (st_q.data),
        .keep ({WORD_BYTES{1'b1}}),
        .dout (dn_wdata)
    );

    assign wr_en = reg_valid && reg_write;

    always_comb begin
        st_d = st_q;
        if (st_q.busy && dn_ack) begin
            st_d.busy = 1'b0;
            if (!st_q.is_wr) begin
                st_d.data = rd_lanes;
            end
        end
        if (wr_en && !st_q.busy) begin
            case (rsel)
                RSEL_CMD: begin
                    st_d.cmd = reg_wdata;
                    if (reg_wdata[CMD_RD_BIT]) begin
                        st_d.busy  = 1'b1;
                        st_d.is_wr = 1'b0;
                    end
                end
                RSEL_DATA: begin
                    st_d.data = reg_wdata;
                    if (!st_q.cmd[CMD_RD_BIT]) begin
                        st_d.busy  = 1'b1;
                        st_d.is_wr = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cmd: '0, data: '0, busy: 1'b0, is_wr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write) begin
            case (rsel)
                RSEL_CMD:    reg_rdata = st_q.cmd;
                RSEL_DATA:   reg_rdata = st_q.data;
                RSEL_STATUS: reg_rdata = {!st_q.busy, {(WORD_W-1){1'b0}}};
                default:     reg_rdata = '0;
            endcase
        end
    end

    assign dn_req  = st_q.busy;
    assign dn_we   = st_q.is_wr;
    assign dn_addr = st_q.cmd[TA_W-1:0];
endmodule

// File: rtl/ibe_checker.sv
module ibe_checker
    import ibe_pkg::*;
#(
    parameter int unsigned RA_W = 12,
    parameter int unsigned TA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_valid,
    input logic              reg_write,
    input logic [RA_W-1:0]   reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              dn_req,
    input logic              dn_we,
    input logic [TA_W-1:0]   dn_addr,
    input logic [CNT_W-1:0]  dn_size,
    input logic [WORD_BYTES-1:0] dn_be,
    input logic              dn_ack
);
    localparam logic [RA_W-1:0] A_CMD    = RA_W'(IDX_CMD * 8);
    localparam logic [RA_W-1:0] A_STATUS = RA_W'(IDX_STATUS * 8);

    logic cmd_wr;
    assign cmd_wr = reg_valid && reg_write && (reg_addr == A_CMD);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_be)); // R11

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ack |=> !dn_req); // R11

    AST_READ_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_req && cmd_wr && reg_wdata[CMD_RD_BIT] |=> dn_req && !dn_we); // R3

    AST_CMD_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_req && cmd_wr && !reg_wdata[CMD_RD_BIT] |=> !dn_req); // R4

    AST_BE_IN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> (dn_be != '0) && ($countones(dn_be) <= int'(dn_size))); // R7

    AST_STATUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_valid && !reg_write && reg_addr == A_STATUS |-> reg_rdata == {!dn_req, {(WORD_W-1){1'b0}}}); // R9

    AST_ACK_CYCLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ack && cmd_wr |=> !dn_req); // R12
endmodule

bind ind_bus_engine ibe_checker #(.RA_W(RA_W), .TA_W(TA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dn_req    (dn_req),
    .dn_we     (dn_we),
    .dn_addr   (dn_addr),
    .dn_size   (dn_size),
    .dn_be     (dn_be),
    .dn_ack    (dn_ack)
);

// File: tb/ind_bus_engine_tb.sv
module ind_bus_engine_tb;
    localparam int RA_W = 12;
    localparam int TA_W = 32;
    localparam logic [RA_W-1:0] A_CMD  = RA_W'('h41 * 8);
    localparam logic [RA_W-1:0] A_DATA = RA_W'('h42 * 8);
    localparam logic [RA_W-1:0] A_STAT = RA_W'('h43 * 8);
    localparam logic [63:0] DONE = 64'h8000_0000_0000_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_valid = 1'b0;
    logic reg_write = 1'b0;
    logic [RA_W-1:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic dn_req, dn_we;
    logic [TA_W-1:0] dn_addr;
    logic [3:0] dn_size;
    logic [7:0] dn_be;
    logic [63:0] dn_wdata;
    logic dn_ack = 1'b0;
    logic [63:0] dn_rdata = '0;

    int n_tests = 0;
    int n_fail = 0;
    int n_req = 0;
    int ack_delay = 1;
    int wait_cnt = 0;
    bit finished = 0;
    logic [31:0] cap_addr;
    logic cap_we;
    logic [7:0] cap_be;
    logic [3:0] cap_size;
    logic [63:0] cap_wdata;

    always #5 clk = ~clk;

    ind_bus_engine #(.RA_W(RA_W), .TA_W(TA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_size(dn_size),
        .dn_be(dn_be), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    function automatic logic [7:0] pat(logic [31:0] a, int i);
        return a[7:0] ^ 8'(8'h5A + i * 37);
    endfunction

    function automatic logic [7:0] exp_be(int offs, int sz);
        logic [7:0] b;
        int lim;
        lim = offs + sz;
        if (lim > 8) lim = 8;
        for (int i = 0; i < 8; i++) b[i] = (i >= offs) && (i < lim);
        return b;
    endfunction

    function automatic logic [63:0] mk_cmd(bit rd, int sz, logic [31:0] a);
        return {rd, 4'b0, 7'(sz), 20'b0, a};
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic reg_wr(logic [RA_W-1:0] a, logic [63:0] d);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(logic [RA_W-1:0] a, output logic [63:0] d);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic wait_done();
        logic [63:0] s;
        wait_cnt = 0;
        do begin
            reg_rd(A_STAT, s);
            wait_cnt++;
        end while (s[63] !== 1'b1 && wait_cnt < 50);
    endtask

    // downstream responder
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (dn_ack) begin
                dn_ack = 1'b0;
                cnt = 0;
            end else if (dn_req) begin
                cnt++;
                if (cnt >= ack_delay) begin
                    dn_ack = 1'b1;
                    n_req++;
                    cap_addr = dn_addr; cap_we = dn_we; cap_be = dn_be;
                    cap_size = dn_size; cap_wdata = dn_wdata;
                    for (int i = 0; i < 8; i++) dn_rdata[i*8 +: 8] = pat(dn_addr, i);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [63:0] v, exp, wv, cmd_keep, data_keep;
        logic [31:0] a;
        int r0, sz_e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R14 reset state
        chk("R14 dn_req", 64'(dn_req), 64'd0);
        reg_rd(A_CMD, v);  chk("R14 cmd", v, 64'd0);
        reg_rd(A_DATA, v); chk("R14 data", v, 64'd0);
        reg_rd(A_STAT, v); chk("R14/R9 status", v, DONE);

        // read sweep over offset and size
        ack_delay = 2;
        for (int offs = 0; offs < 8; offs++) begin
            for (int sz = 1; sz <= 8; sz++) begin
                a = 32'h00A0_0010 + 32'(offs) + 32'(sz << 8);
                r0 = n_req;
                reg_wr(A_CMD, mk_cmd(1'b1, sz, a));
                wait_done();
                chk("R11 one request", 64'(n_req - r0), 64'd1);
                chk("R3 direction", 64'(cap_we), 64'd0);
                chk("R3 address", 64'(cap_addr), 64'(a));
                chk("R7 enables", 64'(cap_be), 64'(exp_be(offs, sz)));
                chk("R6 size", 64'(cap_size), 64'(sz));
                exp = '0;
                for (int o = 0; o < 8; o++)
                    if (exp_be(offs, sz)[o]) exp[(7-o)*8 +: 8] = pat(a, o);
                reg_rd(A_DATA, v);
                chk("R8 read lanes", v, exp);
            end
        end

        // write sweep
        for (int offs = 0; offs < 8; offs++) begin
            for (int sz = 1; sz <= 8; sz += 3) begin
                a = 32'h0BC0_0000 + 32'(offs);
                r0 = n_req;
                reg_wr(A_CMD, mk_cmd(1'b0, sz, a));
                reg_rd(A_STAT, v);
                chk("R4 store only no request", 64'(n_req - r0), 64'd0);
                chk("R4 done stays set", v, DONE);
                wv = 64'h0123_4567_89AB_CDEF ^ 64'(offs * 1000 + sz);
                reg_wr(A_DATA, wv);
                wait_done();
                chk("R5 one write request", 64'(n_req - r0), 64'd1);
                chk("R5 direction", 64'(cap_we), 64'd1);
                chk("R7 write enables", 64'(cap_be), 64'(exp_be(offs, sz)));
                exp = '0;
                for (int o = 0; o < 8; o++) exp[o*8 +: 8] = wv[(7-o)*8 +: 8];
                chk("R8 write lanes", cap_wdata, exp);
                reg_rd(A_DATA, v); chk("R2 data readback", v, wv);
                reg_rd(A_CMD, v);  chk("R2 cmd readback", v, mk_cmd(1'b0, sz, a));
            end
        end

        // size field out of range
        foreach (exp[i]) begin end
        for (int k = 0; k < 4; k++) begin
            sz_e = (k < 2) ? 0 : 100;
            a = 32'h0000_5000 + 32'((k % 2) * 3);
            reg_wr(A_CMD, mk_cmd(1'b1, sz_e, a));
            wait_done();
            chk("R6 clamped size", 64'(cap_size), 64'd8);
            chk("R7 clamped enables", 64'(cap_be), 64'(exp_be((k % 2) * 3, 8)));
        end

        // pending: done low, old data visible, writes ignored
        ack_delay = 5;
        reg_rd(A_DATA, data_keep);
        a = 32'h0000_7702;
        cmd_keep = mk_cmd(1'b1, 4, a);
        r0 = n_req;
        reg_wr(A_CMD, cmd_keep);
        reg_rd(A_STAT, v);  chk("R9 done low while pending", v, 64'd0);
        reg_rd(A_DATA, v);  chk("R10 old data before completion", v, data_keep);
        reg_wr(A_DATA, 64'hDEAD_BEEF_DEAD_BEEF);
        reg_wr(A_CMD, mk_cmd(1'b1, 8, 32'h0000_9990));
        wait_done();
        chk("R12 single request while busy", 64'(n_req - r0), 64'd1);
        reg_rd(A_CMD, v); chk("R12 cmd kept", v, cmd_keep);
        exp = '0;
        for (int o = 2; o < 6; o++) exp[(7-o)*8 +: 8] = pat(a, o);
        reg_rd(A_DATA, v); chk("R12 data from read", v, exp);

        // same-cycle acknowledge and new trigger
        ack_delay = 1;
        r0 = n_req;
        cmd_keep = mk_cmd(1'b1, 2, 32'h0000_1110);
        reg_wr(A_CMD, cmd_keep);
        reg_wr(A_CMD, mk_cmd(1'b1, 2, 32'h0000_2220));
        reg_rd(A_STAT, v); chk("R12 done after ack", v, DONE);
        chk("R12 ack-cycle trigger ignored", 64'(n_req - r0), 64'd1);
        reg_rd(A_CMD, v); chk("R12 ack-cycle cmd kept", v, cmd_keep);
        reg_wr(A_CMD, mk_cmd(1'b1, 2, 32'h0000_2220));
        wait_done();
        chk("R3 later trigger accepted", 64'(n_req - r0), 64'd2);
        chk("R3 later address", 64'(cap_addr), 64'h2220);

        // quiet and unmapped indices, misaligned access
        reg_rd(A_CMD, cmd_keep);
        reg_rd(A_DATA, data_keep);
        r0 = n_req;
        foreach (exp[i]) begin end
        for (int k = 0; k < 6; k++) begin
            logic [RA_W-1:0] qa;
            case (k)
                0: qa = RA_W'('h12 * 8);
                1: qa = RA_W'('h13 * 8);
                2: qa = RA_W'('h18 * 8);
                3: qa = RA_W'('h40 * 8);
                4: qa = RA_W'('h44 * 8);
                default: qa = RA_W'('h1FF * 8);
            endcase
            reg_wr(qa, 64'hFFFF_FFFF_FFFF_FFFF);
            reg_rd(qa, v); chk("R13 quiet index reads zero", v, 64'd0);
        end
        reg_wr(A_CMD + RA_W'(4), mk_cmd(1'b1, 8, 32'h0000_4444));
        reg_wr(A_DATA + RA_W'(2), 64'h1111_2222_3333_4444);
        reg_rd(A_CMD + RA_W'(4), v); chk("R1 misaligned read zero", v, 64'd0);
        reg_rd(A_STAT + RA_W'(1), v); chk("R1 misaligned status zero", v, 64'd0);
        repeat (3) @(negedge clk);
        chk("R1/R13 no request", 64'(n_req - r0), 64'd0);
        reg_rd(A_CMD, v);  chk("R1/R13 cmd untouched", v, cmd_keep);
        reg_rd(A_DATA, v); chk("R1/R13 data untouched", v, data_keep);

        summary();
    end
endmodule